// File: doc/BRIEF.md
# External interrupt sense controller

This block watches eight external interrupt pins and turns each one into an interrupt request line for a CPU. Every pin has its own 2-bit sense code that selects low-level, falling-edge, rising-edge or any-change detection. The pins are brought into the system clock domain through a two-flop synchronizer. A third register keeps the previous sample, and edges are found by comparing two successive samples.

Edge-type events set a sticky pending flag per pin. A flag is set even while the pin is masked, and it is cleared by a per-pin acknowledge pulse or by a write-one-to-clear register. Low-level requests are never latched: they last only while the synchronized pin stays low. A pin's request reaches the CPU only when its mask bit and the global enable input are both set. The upper four pins accept the any-change code. On the lower four pins that same code is reserved and stays silent.

Software reaches the block through a small register port with four addresses: two sense-code registers, a mask register, and the pending flags (read) / flag-clear (write). Writes are synchronous. Reads are combinational.

Top module: `ext_irq_sense`

## Requirements
- R1: An active-high synchronous reset clears both sense-code registers, the mask and every pending flag. After reset every address reads 0 and `irq_o` is 0.
- R2: Code 00 requests an interrupt while the synchronized pin is low. The request drops once the pin is back high, and no pending flag is ever set in this mode.
- R3: Code 10 sets the pin's pending flag when two successive samples go from 1 to 0.
- R4: Code 11 sets the pin's pending flag when two successive samples go from 0 to 1.
- R5: On pins 7..4, code 01 sets the pending flag on any change between two successive samples.
- R6: On pins 3..0, code 01 is reserved and produces neither a request nor a pending flag.
- R7: Address 0 holds the codes of pins 3..0 and address 1 holds those of pins 7..4. Bits [2k+1:2k] of each register are the code of pin k of its group. Address 2 is the mask, with bit k for pin k. All three registers read back what was written.
- R8: `irq_o[k]` is 1 only when mask bit k and `gie_i` are both 1. A pending flag is set even while its pin is masked, and it is delivered as soon as the pin is unmasked.
- R9: A flag stays set until `ack_i[k]` is high for one cycle, or until a write to address 3 has bit k at 1. Bits written as 0 leave their flags unchanged. Reading address 3 returns the pending flags.
- R10: If a new edge event and a clear meet in the same cycle, the flag stays set.
- R11: A pin change driven before clock edge n shows up as a level request after edge n+1 and as a pending flag after edge n+2. A pulse that lasts two clock periods is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | N_PINS (8) | External interrupt pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | N_PINS (8) | Per-pin acknowledge pulse, clears the pending flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (2) | Write address: 0/1 codes, 2 mask, 3 flag clear |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W (2) | Read address: 0/1 codes, 2 mask, 3 pending flags |
| rd_data_o | output | 8 | Read data, combinational |
| irq_o | output | N_PINS (8) | Per-pin interrupt request to the CPU |

## Verification
The assertions assume that reset is asserted from the first clock edge. They also assume that a code rise in a pending flag is always preceded by the code that produced it, so no property reasons across a code change and an event in the same cycle. The stimulus respects this. It changes pins, acknowledges and the enable only at falling clock edges, and it rewrites sense codes only while the pins have been stable for several cycles. After each code change it clears the pending flags before making a new pin transition, so every expected flag pattern comes from exactly one transition.

// File: rtl/eis_pkg.sv
package eis_pkg;
    localparam int GRP_PINS = 4;
    localparam int CODE_W   = 2;
    localparam int REG_W    = GRP_PINS * CODE_W;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;
endpackage

// File: rtl/eis_sampler.sv
module eis_sampler #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] cur_o,
    output logic [N_PINS-1:0] prev_o
);
    typedef struct packed {
        logic [N_PINS-1:0] meta;
        logic [N_PINS-1:0] cur;
        logic [N_PINS-1:0] prev;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_i;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cur_o  = s_q.cur;
    assign prev_o = s_q.prev;
endmodule

// File: rtl/eis_sense.sv
module eis_sense
    import eis_pkg::*;
#(
    parameter int N_PINS   = 8,
    parameter int ANY_FROM = 4
) (
    input  logic [CODE_W*N_PINS-1:0] code_i,
    input  logic [N_PINS-1:0]        cur_i,
    input  logic [N_PINS-1:0]        prev_i,
    output logic [N_PINS-1:0]        evt_o,
    output logic [N_PINS-1:0]        level_o
);
    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
        sense_e mode;
        logic   rise;
        logic   fall;
        logic   hit;

        assign mode       = sense_e'(code_i[CODE_W*k +: CODE_W]);
        assign rise       = cur_i[k] & ~prev_i[k];
        assign fall       = ~cur_i[k] & prev_i[k];
        assign level_o[k] = (mode == SNS_LOW) && !cur_i[k];

        if (k >= ANY_FROM) begin : g_toggle
            always_comb begin
                case (mode)
                    SNS_ANY:  hit = rise | fall;
                    SNS_FALL: hit = fall;
                    SNS_RISE: hit = rise;
                    default:  hit = 1'b0;
                endcase
            end
        end else begin : g_reserved
            always_comb begin
                case (mode)
                    SNS_FALL: hit = fall;
                    SNS_RISE: hit = rise;
                    default:  hit = 1'b0;
                endcase
            end
        end

        assign evt_o[k] = hit;
    end
endmodule

// File: rtl/eis_flags.sv
module eis_flags #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] set_i,
    input  logic [N_PINS-1:0] clr_i,
    output logic [N_PINS-1:0] pend_o
);
    typedef struct packed {
        logic [N_PINS-1:0] pend;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.pend = (f_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign pend_o = f_q.pend;

    for (genvar k = 0; k < N_PINS; k++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> f_q.pend[k]);  // R10
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !f_q.pend[k]);  // R9
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (f_q.pend[k] && !clr_i[k]) |=> f_q.pend[k]);  // R9
    end
endmodule

// File: rtl/eis_regs.sv
module eis_regs
    import eis_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [REG_W-1:0]         wr_data_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    input  logic [N_PINS-1:0]        pend_i,
    output logic [REG_W-1:0]         rd_data_o,
    output logic [CODE_W*N_PINS-1:0] code_o,
    output logic [N_PINS-1:0]        mask_o,
    output logic [N_PINS-1:0]        clr_o
);
    localparam int N_CTRL    = N_PINS / GRP_PINS;
    localparam int MASK_ADDR = N_CTRL;
    localparam int FLAG_ADDR = N_CTRL + 1;

    typedef struct packed {
        logic [N_CTRL-1:0][REG_W-1:0] ctrl;
        logic [N_PINS-1:0]            mask;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        clr_o = '0;
        if (wr_en_i) begin
            for (int g = 0; g < N_CTRL; g++) begin
                if (wr_addr_i == ADDR_W'(g)) r_d.ctrl[g] = wr_data_i;
            end
            if (wr_addr_i == ADDR_W'(MASK_ADDR)) r_d.mask = wr_data_i[N_PINS-1:0];
            if (wr_addr_i == ADDR_W'(FLAG_ADDR)) clr_o = wr_data_i[N_PINS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < N_CTRL; g++) begin
            if (rd_addr_i == ADDR_W'(g)) rd_data_o = r_q.ctrl[g];
        end
        if (rd_addr_i == ADDR_W'(MASK_ADDR)) rd_data_o = REG_W'(r_q.mask);
        if (rd_addr_i == ADDR_W'(FLAG_ADDR)) rd_data_o = REG_W'(pend_i);
    end

    assign code_o = r_q.ctrl;
    assign mask_o = r_q.mask;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter  int N_PINS   = 8,
    parameter  int ANY_FROM = 4,
    localparam int N_CTRL   = N_PINS / GRP_PINS,
    localparam int ADDR_W   = $clog2(N_CTRL + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              gie_i,
    input  logic [N_PINS-1:0] ack_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic [N_PINS-1:0] irq_o
);
    logic [CODE_W*N_PINS-1:0] code_w;
    logic [N_PINS-1:0]        mask_w;
    logic [N_PINS-1:0]        swclr_w;
    logic [N_PINS-1:0]        pend_w;
    logic [N_PINS-1:0]        cur_w;
    logic [N_PINS-1:0]        prev_w;
    logic [N_PINS-1:0]        evt_w;
    logic [N_PINS-1:0]        lvl_w;

    eis_sampler #(.N_PINS(N_PINS)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    eis_sense #(.N_PINS(N_PINS), .ANY_FROM(ANY_FROM)) u_sense (
        .code_i  (code_w),
        .cur_i   (cur_w),
        .prev_i  (prev_w),
        .evt_o   (evt_w),
        .level_o (lvl_w)
    );

    eis_flags #(.N_PINS(N_PINS)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_w),
        .clr_i  (swclr_w | ack_i),
        .pend_o (pend_w)
    );

    eis_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .pend_i    (pend_w),
        .rd_data_o (rd_data_o),
        .code_o    (code_w),
        .mask_o    (mask_w),
        .clr_o     (swclr_w)
    );

    assign irq_o = (lvl_w | pend_w) & mask_w & {N_PINS{gie_i}};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pend_w == '0 && mask_w == '0 && code_w == '0));  // R1

    for (genvar k = 0; k < N_PINS; k++) begin : g_chk
        AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_w[k]) |-> ($past(code_w[CODE_W*k +: CODE_W]) != SNS_LOW));  // R2
        if (k < ANY_FROM) begin : g_rsv
            AST_RSV_SILENT: assert property (@(posedge clk) disable iff (rst)
                $rose(pend_w[k]) |-> ($past(code_w[CODE_W*k +: CODE_W]) != SNS_ANY));  // R6
        end
    end
endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // fields: {codes pins 3..0, codes pins 7..4, pins before, pins after, expected flags}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'hAA, 8'hAA, 8'hFF, 8'h00, 8'hFF},  // R3 falling everywhere
        {8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF},  // R4 rising everywhere
        {8'hAA, 8'hAA, 8'h00, 8'hFF, 8'h00},  // R3 rise ignored in falling mode
        {8'h55, 8'h55, 8'h00, 8'hFF, 8'hF0},  // R5 R6 any-change vs reserved
        {8'h55, 8'h55, 8'hFF, 8'h00, 8'hF0},  // R5 R6 opposite direction
        {8'hAA, 8'hFF, 8'h0F, 8'hF0, 8'hFF},  // R3 R4 split groups
        {8'hAA, 8'hFF, 8'hF0, 8'h0F, 8'h00},  // R3 R4 wrong directions
        {8'h1B, 8'h1B, 8'h00, 8'hFF, 8'h51},  // R7 per-pin field layout, rising
        {8'h1B, 8'h1B, 8'hFF, 8'h00, 8'h62},  // R7 per-pin field layout, falling
        {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00}   // R2 level mode keeps no flag
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pins;
    logic       gie;
    logic [7:0] ack;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic [7:0] irq;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;
    logic [7:0] got, v_lo, v_hi, v_bf, v_af, v_ex;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_sense uut (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pins),
        .gie_i     (gie),
        .ack_i     (ack),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pins = 8'hFF; gie = 1'b0; ack = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), got);
            check("R1 register after reset", got, 8'h00);
        end
        check("R1 irq after reset", irq, 8'h00);

        // R7 register readback
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h5A);
        rd(2'd0, got); check("R7 code reg pins 3..0", got, 8'hA5);
        rd(2'd1, got); check("R7 code reg pins 7..4", got, 8'h3C);
        rd(2'd2, got); check("R7 mask reg", got, 8'h5A);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            {v_lo, v_hi, v_bf, v_af, v_ex} = VEC[i];
            wr(2'd2, 8'h00);
            wr(2'd0, v_lo);
            wr(2'd1, v_hi);
            pins = v_bf;
            tick(5);
            wr(2'd3, 8'hFF);
            pins = v_af;
            tick(5);
            rd(2'd3, got);
            check($sformatf("table entry %0d flags", i), got, v_ex);
        end

        // R2 R11 level request and its latency
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h02);
        gie = 1'b1;
        pins = 8'hFF;
        tick(4);
        check("R2 no request with pins high", irq, 8'h00);
        pins[1] = 1'b0;
        tick(1);
        check("R11 level not yet after one edge", irq, 8'h00);
        tick(1);
        check("R11 R2 level request after two edges", irq, 8'h02);
        pins[1] = 1'b1;
        tick(2);
        check("R2 level request drops with pin high", irq, 8'h00);
        rd(2'd3, got); check("R2 no flag kept in level mode", got, 8'h00);

        // R4 R11 edge latency
        wr(2'd0, 8'h03); wr(2'd2, 8'h01);
        pins[0] = 1'b0;
        tick(4);
        wr(2'd3, 8'hFF);
        pins[0] = 1'b1;
        tick(2);
        check("R11 edge not yet after two edges", irq, 8'h00);
        tick(1);
        check("R11 R4 edge request after three edges", irq, 8'h01);

        // R11 two-period pulse
        wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h02);
        wr(2'd3, 8'hFF);
        pins[4] = 1'b0;
        tick(2);
        pins[4] = 1'b1;
        tick(4);
        rd(2'd3, got); check("R11 two-period pulse caught", got, 8'h10);

        // R8 gating, R9 acknowledge
        check("R8 masked flag gives no request", irq, 8'h00);
        wr(2'd2, 8'h10);
        gie = 1'b0;
        #1;
        check("R8 global enable off", irq, 8'h00);
        gie = 1'b1;
        #1;
        check("R8 unmasked flag delivered", irq, 8'h10);
        @(negedge clk);
        ack = 8'h10;
        tick(1);
        ack = 8'h00;
        check("R9 ack removes request", irq, 8'h00);
        rd(2'd3, got); check("R9 ack clears flag", got, 8'h00);

        // R9 partial write-one-to-clear
        wr(2'd2, 8'h00); wr(2'd0, 8'hAA); wr(2'd1, 8'hAA);
        pins = 8'hFF;
        tick(4);
        wr(2'd3, 8'hFF);
        pins = 8'h00;
        tick(4);
        rd(2'd3, got); check("R3 all falling flags", got, 8'hFF);
        wr(2'd3, 8'h0F);
        rd(2'd3, got); check("R9 zero bits leave flags", got, 8'hF0);

        // R10 event and acknowledge collide
        wr(2'd3, 8'hFF); wr(2'd0, 8'h00); wr(2'd1, 8'h10);
        pins[6] = 1'b1;
        tick(4);
        rd(2'd3, got); check("R5 any-change flag pin 6", got, 8'h40);
        pins[6] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ack = 8'h40;
        @(posedge clk);
        @(negedge clk);
        ack = 8'h00;
        rd(2'd3, got); check("R10 set wins over ack", got, 8'h40);
        ack = 8'h40;
        tick(1);
        ack = 8'h00;
        rd(2'd3, got); check("R9 plain ack clears", got, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule